// File: doc/BRIEF.md
# IDE Channel Interrupt Router

This unit takes the active-high interrupt requests of a primary and a secondary IDE channel and presents them to the system in one of two arrangements, chosen by a single mode input. In the legacy arrangement each channel owns a dedicated active-high interrupt line. In the native arrangement both channels share one active-low output that is pulled low when either channel requests service, and the dedicated lines stay quiet.

Changing the mode input opens a masking window. For a fixed number of clocks all three outputs are held inactive, so the downstream interrupt logic never sees a glitch from a half-finished reconfiguration. A request that is still present when the window closes appears on the output right away. A request that went away during the window leaves no trace. All outputs are registered, so each output reflects the inputs sampled at the previous clock edge.

Top module: `ide_irq_route`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `legacy_pri_irq` and `legacy_sec_irq` are 0 and `shared_irq_n` is 1. The unit leaves reset in legacy arrangement (`native_mode` = 0 selects legacy and 1 selects native).
- R2: In legacy arrangement, outside a masking window, `legacy_pri_irq` equals `pri_req` and `legacy_sec_irq` equals `sec_req` as sampled at the previous clock edge.
- R3: In legacy arrangement, `shared_irq_n` stays 1 whatever the requests are.
- R4: In native arrangement, outside a masking window, `shared_irq_n` is 0 one clock after either request is high, and 1 one clock after both are low.
- R5: In native arrangement, `legacy_pri_irq` and `legacy_sec_irq` stay 0 whatever the requests are.
- R6: A clock edge at which `native_mode` differs from its value at the previous edge starts a masking window. From that edge, the outputs of MASK_CYCLES (default 16) consecutive cycles are inactive (0, 0, 1).
- R7: A request that is high at the last masked edge is driven onto the output of the newly selected arrangement on the first cycle after the window.
- R8: A mode change that occurs inside a window restarts the full MASK_CYCLES window from that edge.
- R9: A request that rises and falls again inside a window causes no output assertion, either during the window or after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_req | input | 1 | Primary channel interrupt request, active high |
| sec_req | input | 1 | Secondary channel interrupt request, active high |
| native_mode | input | 1 | Arrangement select: 0 legacy, 1 native |
| legacy_pri_irq | output | 1 | Dedicated primary interrupt line, active high |
| legacy_sec_irq | output | 1 | Dedicated secondary interrupt line, active high |
| shared_irq_n | output | 1 | Shared native interrupt, active low |

## Verification
The close of the masking window and a change on the inputs can land on the same edge. Two cases matter: a request that first appears at the last masked edge, and a mode toggle that arrives exactly when the window would expire. The bench drives a secondary request just before the final masked edge and expects it on the shared output one cycle later, no earlier. It also toggles the mode midway through a window and expects sixteen more masked cycles counted from the toggle, not from the first change.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

    typedef enum logic {
        ROUTE_LEGACY = 1'b0,
        ROUTE_NATIVE = 1'b1
    } route_mode_e;

    typedef struct packed {
        logic pri;
        logic sec;
    } chan_req_t;

    typedef struct packed {
        logic pri_line;
        logic sec_line;
        logic shared_n;
    } irq_out_t;

    localparam irq_out_t IRQ_IDLE = '{pri_line: 1'b0, sec_line: 1'b0, shared_n: 1'b1};

    // Output pattern for a given arrangement, request pair and mask state.
    function automatic irq_out_t route_irq(route_mode_e m, chan_req_t r, logic masked);
        irq_out_t o;
        o = IRQ_IDLE;
        if (!masked) begin
            case (m)
                ROUTE_LEGACY: begin
                    o.pri_line = r.pri;
                    o.sec_line = r.sec;
                end
                ROUTE_NATIVE: begin
                    o.shared_n = ~(r.pri | r.sec);
                end
                default: o = IRQ_IDLE;
            endcase
        end
        return o;
    endfunction

endpackage

// File: rtl/ide_irq_mode_track.sv
module ide_irq_mode_track
    import ide_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        native_mode,
    output route_mode_e mode_next,
    output logic        mode_change
);

    route_mode_e mode_q;

    assign mode_next   = route_mode_e'(native_mode);
    assign mode_change = (mode_next != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ROUTE_LEGACY;
        end else begin
            mode_q <= mode_next;
        end
    end

endmodule

// File: rtl/ide_irq_mask_timer.sv
module ide_irq_mask_timer #(
    parameter int MASK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic mask_next,
    output logic mask_q
);

    generate
        if (MASK_CYCLES > 0) begin : g_cnt
            localparam int CNT_W = $clog2(MASK_CYCLES + 1);
            localparam logic [CNT_W-1:0] LOAD = CNT_W'(MASK_CYCLES);

            logic [CNT_W-1:0] cnt_q;
            logic [CNT_W-1:0] cnt_d;

            always_comb begin
                if (restart) begin
                    cnt_d = LOAD;
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    cnt_d = '0;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign mask_next = (cnt_d != '0);
            assign mask_q    = (cnt_q != '0);
        end else begin : g_none
            assign mask_next = 1'b0;
            assign mask_q    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ide_irq_router.sv
module ide_irq_router
    import ide_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  route_mode_e mode,
    input  chan_req_t   req,
    input  logic        masked,
    output irq_out_t    irq_q
);

    irq_out_t irq_d;

    assign irq_d = route_irq(mode, req, masked);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= IRQ_IDLE;
        end else begin
            irq_q <= irq_d;
        end
    end

endmodule

// File: rtl/ide_irq_route.sv
module ide_irq_route
    import ide_irq_pkg::*;
#(
    parameter int MASK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pri_req,
    input  logic sec_req,
    input  logic native_mode,
    output logic legacy_pri_irq,
    output logic legacy_sec_irq,
    output logic shared_irq_n
);

    chan_req_t   req;
    route_mode_e mode_next;
    logic        mode_change;
    logic        mask_next;
    logic        mask_q;
    irq_out_t    irq_q;

    assign req = '{pri: pri_req, sec: sec_req};

    ide_irq_mode_track u_mode (
        .clk         (clk),
        .rst         (rst),
        .native_mode (native_mode),
        .mode_next   (mode_next),
        .mode_change (mode_change)
    );

    ide_irq_mask_timer #(
        .MASK_CYCLES (MASK_CYCLES)
    ) u_mask (
        .clk       (clk),
        .rst       (rst),
        .restart   (mode_change),
        .mask_next (mask_next),
        .mask_q    (mask_q)
    );

    ide_irq_router u_route (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode_next),
        .req    (req),
        .masked (mask_next),
        .irq_q  (irq_q)
    );

    assign legacy_pri_irq = irq_q.pri_line;
    assign legacy_sec_irq = irq_q.sec_line;
    assign shared_irq_n   = irq_q.shared_n;

endmodule

// File: rtl/ide_irq_route_chk.sv
module ide_irq_route_chk #(
    parameter int MASK_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic pri_req,
    input logic sec_req,
    input logic native_mode,
    input logic legacy_pri_irq,
    input logic legacy_sec_irq,
    input logic shared_irq_n,
    input logic mode_change,
    input logic mask_q
);

    localparam int WIN_W = $clog2(MASK_CYCLES + 1);
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(MASK_CYCLES);

    logic [WIN_W-1:0] win_cnt;

    // Independent window counter used to check the window length.
    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
        end else if (mode_change) begin
            win_cnt <= WIN_LOAD;
        end else if (win_cnt != '0) begin
            win_cnt <= win_cnt - 1'b1;
        end
    end

    a_r2_legacy_follow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !mask_q && !$past(native_mode)) |->
        (legacy_pri_irq == $past(pri_req) && legacy_sec_irq == $past(sec_req)));

    a_r3_legacy_shared_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(native_mode) |-> shared_irq_n);

    a_r4_native_or: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !mask_q && $past(native_mode)) |->
        (shared_irq_n == !($past(pri_req) || $past(sec_req))));

    a_r5_native_legacy_idle: assert property (@(posedge clk) disable iff (rst)
        $past(native_mode) |-> (!legacy_pri_irq && !legacy_sec_irq));

    a_r6_masked_idle: assert property (@(posedge clk) disable iff (rst)
        mask_q |-> (shared_irq_n && !legacy_pri_irq && !legacy_sec_irq));

    a_r6_window_open: assert property (@(posedge clk) disable iff (rst)
        (win_cnt != '0) |-> mask_q);

    a_r7_window_closed: assert property (@(posedge clk) disable iff (rst)
        (win_cnt == '0) |-> !mask_q);

    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        mode_change |=> mask_q);

endmodule

bind ide_irq_route ide_irq_route_chk #(
    .MASK_CYCLES (MASK_CYCLES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .pri_req        (pri_req),
    .sec_req        (sec_req),
    .native_mode    (native_mode),
    .legacy_pri_irq (legacy_pri_irq),
    .legacy_sec_irq (legacy_sec_irq),
    .shared_irq_n   (shared_irq_n),
    .mode_change    (mode_change),
    .mask_q         (mask_q)
);

// File: tb/tb_ide_irq_route.sv
module tb_ide_irq_route;

    localparam int MASK = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pri_req = 1'b0;
    logic sec_req = 1'b0;
    logic native_mode = 1'b0;
    logic legacy_pri_irq;
    logic legacy_sec_irq;
    logic shared_irq_n;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    ide_irq_route #(.MASK_CYCLES(MASK)) dut (
        .clk            (clk),
        .rst            (rst),
        .pri_req        (pri_req),
        .sec_req        (sec_req),
        .native_mode    (native_mode),
        .legacy_pri_irq (legacy_pri_irq),
        .legacy_sec_irq (legacy_sec_irq),
        .shared_irq_n   (shared_irq_n)
    );

    localparam logic [2:0] IDLE = 3'b001;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Observed vector is {legacy_pri_irq, legacy_sec_irq, shared_irq_n}.
    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] obs;
        obs = {legacy_pri_irq, legacy_sec_irq, shared_irq_n};
        compared++;
        if (obs !== exp) begin
            mismatched++;
            $display("FAIL %s: got %b expected %b", tag, obs, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        pri_req = 1'b0;
        sec_req = 1'b0;
        native_mode = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        chk("R1 in reset", IDLE);
        pri_req = 1'b1;
        tick();
        chk("R1 reset holds with request", IDLE);
        rst = 1'b0;
        pri_req = 1'b0;
        tick();
        chk("R1 first cycle after reset", IDLE);
    endtask

    task automatic t_legacy();
        pri_req = 1'b1; sec_req = 1'b0; tick();
        chk("R2 R3 legacy primary", 3'b101);
        sec_req = 1'b1; tick();
        chk("R2 R3 legacy both", 3'b111);
        pri_req = 1'b0; tick();
        chk("R2 R3 legacy secondary", 3'b011);
        sec_req = 1'b0; tick();
        chk("R2 legacy none", IDLE);
    endtask

    task automatic t_to_native();
        native_mode = 1'b1;
        pri_req = 1'b1;
        for (int i = 1; i <= MASK; i++) begin
            tick();
            chk("R6 window to native", IDLE);
        end
        tick();
        chk("R7 pending request after window", 3'b000);
        pri_req = 1'b0; sec_req = 1'b1; tick();
        chk("R4 R5 native secondary", 3'b000);
        sec_req = 1'b0; tick();
        chk("R4 native none", IDLE);
        pri_req = 1'b1; sec_req = 1'b1; tick();
        chk("R4 R5 native both", 3'b000);
        pri_req = 1'b0; sec_req = 1'b0; tick();
        chk("R4 native release", IDLE);
    endtask

    task automatic t_drop_in_window();
        native_mode = 1'b0;
        for (int i = 1; i <= MASK; i++) begin
            pri_req = (i >= 9 && i <= 12);
            tick();
            chk("R6 R9 window to legacy", IDLE);
        end
        pri_req = 1'b0;
        tick();
        chk("R9 dropped request stays silent", IDLE);
        pri_req = 1'b1; tick();
        chk("R2 legacy after window", 3'b101);
    endtask

    task automatic t_restart();
        native_mode = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            tick();
            chk("R6 first window", IDLE);
        end
        native_mode = 1'b0;
        for (int i = 1; i <= MASK; i++) begin
            tick();
            chk("R8 restarted window", IDLE);
        end
        tick();
        chk("R8 R7 legacy after restart", 3'b101);
        pri_req = 1'b0; tick();
        chk("R2 legacy clear", IDLE);
    endtask

    task automatic t_boundary();
        native_mode = 1'b1;
        for (int i = 1; i < MASK; i++) begin
            tick();
            chk("R6 boundary window", IDLE);
        end
        sec_req = 1'b1;
        tick();
        chk("R6 last masked cycle", IDLE);
        tick();
        chk("R7 request at last masked edge", 3'b000);
        sec_req = 1'b0; tick();
        chk("R4 after boundary", IDLE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_legacy();
        t_to_native();
        t_drop_in_window();
        t_restart();
        t_boundary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule